// File: doc/BRIEF.md
# Indirect Message Bus Window Bridge

This block gives a host processor access to registers on an internal message bus. It does not map those registers directly. The host sees three 32-bit words in its own register window:

- a command word, which carries the opcode, the endpoint number, the low byte of the target address and a byte-enable nibble;
- an upper-address word, which carries address bits 31:8;
- a payload word, which holds write data on the way out and read data on the way back.

A host write to the command word starts one transaction on the message bus. While that transaction is open, the host interface holds its ready signal low.

To write, the host loads the payload word, then the upper-address word, then the command word. The request then carries the payload word as its write data. To read, the host loads the upper-address word and then the command word. It polls until ready returns and then reads the returned value back from the payload word. The endpoint number selects a target on the message bus, and the 32-bit register address selects a location inside that target. The two are independent of each other.

Top module: `msgwin_bridge`

## Requirements
- R1: After reset all three window words read as zero, the bus request is low and host ready is high.
- R2: The command word sits at offset 0xD0, the upper-address word at 0xD4 and the payload word at 0xD8. Each reads back the last value written to it. Any other offset reads as zero, and writes to other offsets change nothing.
- R3: While a request is open, the request fields come from the window words:
  - opcode is command bits 31:24;
  - endpoint number is command bits 23:16;
  - the 32-bit target address is upper-address bits 31:8 joined above command bits 15:8.
- R4: Only six opcodes are launched: 0x10 and 0x11 (normal), 0x06 and 0x07 (alternate), 0x02 and 0x03 (I/O). An odd opcode is a write (write flag high) and an even opcode is a read.
- R5: Normal-class requests always carry byte enables 0xF. Alternate and I/O requests carry command bits 7:4 as byte enables.
- R6: Each host write of a launchable opcode to the command word raises the request on the next cycle. The request is held with stable fields until the cycle it is acknowledged, and it drops after that cycle. Exactly one request is issued per command write.
- R7: Host ready is low for exactly the cycles a request is open. A host write offered while ready is low changes no window word.
- R8: A write request carries the payload word as write data, and a write leaves the payload word unchanged.
- R9: When a read request is acknowledged, the returned data is loaded into the payload word.
- R10: A command write with any other opcode issues no request and keeps ready high. If its bit 0 is zero it sets the payload word to all ones; otherwise the payload word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | HOST_AW | Host register offset |
| hostWr | input | 1 | Host write strobe, taken when hostReady is high |
| hostWdata | input | 32 | Host write data |
| hostRd | input | 1 | Host read strobe |
| hostRdata | output | 32 | Selected window word, valid while hostRd and hostReady are high |
| hostReady | output | 1 | High when the bridge accepts a host access |
| msgReq | output | 1 | Message bus request |
| msgWrite | output | 1 | Request is a write |
| msgOp | output | 8 | Request opcode |
| msgPort | output | 8 | Target endpoint number |
| msgAddr | output | 32 | Target register address |
| msgBe | output | 4 | Byte enables |
| msgWdata | output | 32 | Write data, which is the payload word |
| msgAck | input | 1 | Endpoint acknowledge, one cycle, only while msgReq is high |
| msgRdata | input | 32 | Read data, valid with msgAck |

## Verification
The bench builds the bridge with its default parameters: an 8-bit host offset, the three window words at 0xD0, 0xD4 and 0xD8, and forced full byte enables for the normal class. With these values the bench covers every opcode class, the byte-enable override, and acknowledges that arrive in the first cycle of a request as well as several cycles later. It also covers writes offered while a request is open and command writes with opcodes outside the launchable set.

// File: rtl/msgwin_pkg.sv
package msgwin_pkg;

  localparam int WORD_W = 32;

  // Command word field positions (decoded by the datapath and the control)
  localparam int OP_HI   = 31;
  localparam int OP_LO   = 24;
  localparam int PORT_HI = 23;
  localparam int PORT_LO = 16;
  localparam int ALO_HI  = 15;
  localparam int ALO_LO  = 8;
  localparam int BE_HI   = 7;
  localparam int BE_LO   = 4;

  localparam logic [7:0] OP_NRM_RD = 8'h10;
  localparam logic [7:0] OP_ALT_RD = 8'h06;
  localparam logic [7:0] OP_IO_RD  = 8'h02;

  typedef enum logic [1:0] {CLS_BAD, CLS_NRM, CLS_ALT, CLS_IO} opClass_e;

  typedef enum logic {ST_IDLE, ST_WAIT} brState_e;

  // Load and capture strobes from the control to the datapath
  typedef struct packed {
    logic ldCtrl;
    logic ldExt;
    logic ldData;
    logic capRead;
    logic fillOnes;
  } dpStrobe_t;

  // Opcodes come in read/write pairs that differ only in bit 0
  function automatic opClass_e classifyOp(input logic [7:0] op);
    opClass_e cls;
    if (op[7:1] == OP_NRM_RD[7:1])      cls = CLS_NRM;
    else if (op[7:1] == OP_ALT_RD[7:1]) cls = CLS_ALT;
    else if (op[7:1] == OP_IO_RD[7:1])  cls = CLS_IO;
    else                                cls = CLS_BAD;
    return cls;
  endfunction

endpackage

// File: rtl/msgwin_ctrl.sv
module msgwin_ctrl
  import msgwin_pkg::*;
#(
  parameter int                  HOST_AW  = 8,
  parameter logic [HOST_AW-1:0]  CTRL_OFS = HOST_AW'('hD0),
  parameter logic [HOST_AW-1:0]  EXT_OFS  = HOST_AW'('hD4),
  parameter logic [HOST_AW-1:0]  DATA_OFS = HOST_AW'('hD8)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWr,
  input  logic [7:0]         newOp,
  input  logic               curWrite,
  input  logic               msgAck,
  output dpStrobe_t          strobe,
  output logic               msgReq,
  output logic               hostReady
);

  brState_e stateQ, stateD;
  logic     accept;
  logic     newBad;
  logic     launch;

  assign accept = hostWr && (stateQ == ST_IDLE);
  assign newBad = (classifyOp(newOp) == CLS_BAD);

  always_comb begin
    strobe          = '0;
    strobe.ldCtrl   = accept && (hostAddr == CTRL_OFS);
    strobe.ldExt    = accept && (hostAddr == EXT_OFS);
    strobe.ldData   = accept && (hostAddr == DATA_OFS);
    strobe.fillOnes = strobe.ldCtrl && newBad && !newOp[0];
    strobe.capRead  = (stateQ == ST_WAIT) && msgAck && !curWrite;
  end

  assign launch = accept && (hostAddr == CTRL_OFS) && !newBad;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (launch) stateD = ST_WAIT;
      ST_WAIT: if (msgAck) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign msgReq    = (stateQ == ST_WAIT);
  assign hostReady = (stateQ == ST_IDLE);

endmodule

// File: rtl/msgwin_dpath.sv
module msgwin_dpath
  import msgwin_pkg::*;
#(
  parameter int                  HOST_AW       = 8,
  parameter logic [HOST_AW-1:0]  CTRL_OFS      = HOST_AW'('hD0),
  parameter logic [HOST_AW-1:0]  EXT_OFS       = HOST_AW'('hD4),
  parameter logic [HOST_AW-1:0]  DATA_OFS      = HOST_AW'('hD8),
  parameter bit                  FORCE_FULL_BE = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostRd,
  input  logic               hostReady,
  input  logic [WORD_W-1:0]  hostWdata,
  output logic [WORD_W-1:0]  hostRdata,
  input  logic [WORD_W-1:0]  msgRdata,
  output logic               msgWrite,
  output logic [7:0]         msgOp,
  output logic [7:0]         msgPort,
  output logic [WORD_W-1:0]  msgAddr,
  output logic [3:0]         msgBe,
  output logic [WORD_W-1:0]  msgWdata
);

  logic [WORD_W-1:0] ctrlQ, extQ, dataQ;
  opClass_e          curCls;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      extQ  <= '0;
    end else begin
      if (strobe.ldCtrl) ctrlQ <= hostWdata;
      if (strobe.ldExt)  extQ  <= hostWdata;
    end
  end

  // The payload word has three sources: host load, read capture, all-ones fill
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dataQ <= '0;
    else if (strobe.fillOnes) dataQ <= '1;
    else if (strobe.capRead)  dataQ <= msgRdata;
    else if (strobe.ldData)   dataQ <= hostWdata;
  end

  assign msgOp    = ctrlQ[OP_HI:OP_LO];
  assign msgPort  = ctrlQ[PORT_HI:PORT_LO];
  assign msgAddr  = {extQ[WORD_W-1:8], ctrlQ[ALO_HI:ALO_LO]};
  assign msgWrite = ctrlQ[OP_LO];
  assign msgWdata = dataQ;
  assign curCls   = classifyOp(ctrlQ[OP_HI:OP_LO]);

  generate
    if (FORCE_FULL_BE) begin : g_forceBe
      assign msgBe = (curCls == CLS_NRM) ? 4'hF : ctrlQ[BE_HI:BE_LO];
    end else begin : g_passBe
      assign msgBe = ctrlQ[BE_HI:BE_LO];
    end
  endgenerate

  always_comb begin
    hostRdata = '0;
    if (hostRd && hostReady) begin
      if (hostAddr == CTRL_OFS)      hostRdata = ctrlQ;
      else if (hostAddr == EXT_OFS)  hostRdata = extQ;
      else if (hostAddr == DATA_OFS) hostRdata = dataQ;
    end
  end

endmodule

// File: rtl/msgwin_bridge.sv
module msgwin_bridge
  import msgwin_pkg::*;
#(
  parameter int                  HOST_AW       = 8,
  parameter logic [HOST_AW-1:0]  CTRL_OFS      = HOST_AW'('hD0),
  parameter logic [HOST_AW-1:0]  EXT_OFS       = HOST_AW'('hD4),
  parameter logic [HOST_AW-1:0]  DATA_OFS      = HOST_AW'('hD8),
  parameter bit                  FORCE_FULL_BE = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWr,
  input  logic [31:0]        hostWdata,
  input  logic               hostRd,
  output logic [31:0]        hostRdata,
  output logic               hostReady,
  output logic               msgReq,
  output logic               msgWrite,
  output logic [7:0]         msgOp,
  output logic [7:0]         msgPort,
  output logic [31:0]        msgAddr,
  output logic [3:0]         msgBe,
  output logic [31:0]        msgWdata,
  input  logic               msgAck,
  input  logic [31:0]        msgRdata
);

  dpStrobe_t strobe;

  msgwin_ctrl #(
    .HOST_AW(HOST_AW), .CTRL_OFS(CTRL_OFS), .EXT_OFS(EXT_OFS), .DATA_OFS(DATA_OFS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .newOp(hostWdata[OP_HI:OP_LO]), .curWrite(msgWrite), .msgAck(msgAck),
    .strobe(strobe), .msgReq(msgReq), .hostReady(hostReady)
  );

  msgwin_dpath #(
    .HOST_AW(HOST_AW), .CTRL_OFS(CTRL_OFS), .EXT_OFS(EXT_OFS), .DATA_OFS(DATA_OFS),
    .FORCE_FULL_BE(FORCE_FULL_BE)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostAddr(hostAddr), .hostRd(hostRd),
    .hostReady(hostReady), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .msgRdata(msgRdata), .msgWrite(msgWrite), .msgOp(msgOp), .msgPort(msgPort),
    .msgAddr(msgAddr), .msgBe(msgBe), .msgWdata(msgWdata)
  );

endmodule

// File: rtl/msgwin_checker.sv
module msgwin_checker #(
  parameter int                 HOST_AW  = 8,
  parameter logic [HOST_AW-1:0] CTRL_OFS = HOST_AW'('hD0)
) (
  input logic               clk,
  input logic               rstN,
  input logic [HOST_AW-1:0] hostAddr,
  input logic               hostWr,
  input logic [31:0]        hostWdata,
  input logic               hostReady,
  input logic               msgReq,
  input logic               msgWrite,
  input logic [7:0]         msgOp,
  input logic [31:0]        msgAddr,
  input logic [3:0]         msgBe,
  input logic [31:0]        msgWdata,
  input logic               msgAck,
  input logic [31:0]        msgRdata
);

  logic newOk;
  assign newOk = hostWdata[31:24] inside {8'h10, 8'h11, 8'h06, 8'h07, 8'h02, 8'h03};

  a_r6_req_held: assert property (@(posedge clk) disable iff (!rstN)
    msgReq && !msgAck |=> msgReq);

  a_r6_req_drops: assert property (@(posedge clk) disable iff (!rstN)
    msgReq && msgAck |=> !msgReq);

  a_r6_fields_stable: assert property (@(posedge clk) disable iff (!rstN)
    msgReq && !msgAck |=> $stable(msgOp) && $stable(msgAddr) && $stable(msgWdata) && $stable(msgBe));

  a_r7_ready_vs_req: assert property (@(posedge clk) disable iff (!rstN)
    hostReady != msgReq);

  a_r4_op_legal: assert property (@(posedge clk) disable iff (!rstN)
    msgReq |-> (msgOp inside {8'h10, 8'h11, 8'h06, 8'h07, 8'h02, 8'h03}) && (msgWrite == msgOp[0]));

  a_r5_normal_full_be: assert property (@(posedge clk) disable iff (!rstN)
    msgReq && (msgOp[7:1] == 7'h08) |-> msgBe == 4'hF);

  a_r9_read_capture: assert property (@(posedge clk) disable iff (!rstN)
    msgReq && msgAck && !msgWrite |=> msgWdata == $past(msgRdata));

  a_r8_write_keeps_data: assert property (@(posedge clk) disable iff (!rstN)
    msgReq && msgAck && msgWrite |=> $stable(msgWdata));

  a_r10_bad_no_launch: assert property (@(posedge clk) disable iff (!rstN)
    hostWr && hostReady && (hostAddr == CTRL_OFS) && !newOk |=> !msgReq);

  a_r6_launch: assert property (@(posedge clk) disable iff (!rstN)
    hostWr && hostReady && (hostAddr == CTRL_OFS) && newOk |=> msgReq);

endmodule

bind msgwin_bridge msgwin_checker #(.HOST_AW(HOST_AW), .CTRL_OFS(CTRL_OFS)) u_chk (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostWdata(hostWdata),
  .hostReady(hostReady), .msgReq(msgReq), .msgWrite(msgWrite), .msgOp(msgOp),
  .msgAddr(msgAddr), .msgBe(msgBe), .msgWdata(msgWdata), .msgAck(msgAck),
  .msgRdata(msgRdata)
);

// File: tb/tb_msgwin_bridge.sv
`timescale 1ns/1ps
module tb_msgwin_bridge;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CO = 8'hD0, EO = 8'hD4, DO = 8'hD8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic        hostWr = 1'b0, hostRd = 1'b0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostReady, msgReq, msgWrite;
  logic [7:0]  msgOp, msgPort;
  logic [31:0] msgAddr, msgWdata;
  logic [3:0]  msgBe;
  logic        msgAck = 1'b0;
  logic [31:0] msgRdata = '0;

  msgwin_bridge dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostWdata(hostWdata),
    .hostRd(hostRd), .hostRdata(hostRdata), .hostReady(hostReady), .msgReq(msgReq),
    .msgWrite(msgWrite), .msgOp(msgOp), .msgPort(msgPort), .msgAddr(msgAddr),
    .msgBe(msgBe), .msgWdata(msgWdata), .msgAck(msgAck), .msgRdata(msgRdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- endpoint model ----------------
  logic [31:0] mem [logic [39:0]];
  int ackDelay = 1, waitCnt = 0, reqRises = 0;

  function automatic logic [31:0] dflt(input logic [39:0] k);
    return {k[7:0] ^ 8'h5A, k[39:32], k[15:0]};
  endfunction

  always @(negedge clk) begin
    logic [39:0] k;
    logic [31:0] old, mask;
    if (msgAck) msgAck = 1'b0;
    else if (msgReq) begin
      if (waitCnt >= ackDelay) begin
        waitCnt = 0;
        k = {msgPort, msgAddr};
        old = mem.exists(k) ? mem[k] : dflt(k);
        if (msgWrite) begin
          for (int b = 0; b < 4; b++) mask[b*8 +: 8] = {8{msgBe[b]}};
          mem[k] = (old & ~mask) | (msgWdata & mask);
        end else begin
          msgRdata = old;
        end
        msgAck = 1'b1;
      end else waitCnt++;
    end
  end

  // ---------------- cycle reference model ----------------
  logic [31:0] mCtrl, mExt, mData;
  bit mBusy;
  int expLaunch = 0;

  function automatic bit legalOp(input logic [7:0] op);
    return op == 8'h10 || op == 8'h11 || op == 8'h06 || op == 8'h07 || op == 8'h02 || op == 8'h03;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mExt = 0; mData = 0; mBusy = 0;
    end else if (!mBusy) begin
      if (hostWr) begin
        if (hostAddr == EO) mExt = hostWdata;
        else if (hostAddr == DO) mData = hostWdata;
        else if (hostAddr == CO) begin
          mCtrl = hostWdata;
          if (legalOp(hostWdata[31:24])) begin mBusy = 1; expLaunch++; end
          else if (!hostWdata[24]) mData = 32'hFFFF_FFFF;
        end
      end
    end else if (msgAck) begin
      if (!mCtrl[24]) mData = msgRdata;
      mBusy = 0;
    end
  end

  logic prevReq = 0;
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      logic [31:0] expRd;
      if (msgReq && !prevReq) reqRises++;
      cmp("R7 hostReady", {31'd0, hostReady}, {31'd0, !mBusy});
      cmp("R6 msgReq", {31'd0, msgReq}, {31'd0, mBusy});
      if (mBusy) begin
        cmp("R3 msgOp", {24'd0, msgOp}, {24'd0, mCtrl[31:24]});
        cmp("R3 msgPort", {24'd0, msgPort}, {24'd0, mCtrl[23:16]});
        cmp("R3 msgAddr", msgAddr, {mExt[31:8], mCtrl[15:8]});
        cmp("R4 msgWrite", {31'd0, msgWrite}, {31'd0, mCtrl[24]});
        cmp("R5 msgBe", {28'd0, msgBe},
            {28'd0, (mCtrl[31:25] == 7'h08) ? 4'hF : mCtrl[7:4]});
        cmp("R8 msgWdata", msgWdata, mData);
      end
      expRd = 0;
      if (hostRd && !mBusy) begin
        if (hostAddr == CO) expRd = mCtrl;
        else if (hostAddr == EO) expRd = mExt;
        else if (hostAddr == DO) expRd = mData;
      end
      cmp("R2 hostRdata", hostRdata, expRd);
    end
    prevReq = msgReq;
  end

  // ---------------- host tasks ----------------
  task automatic hostWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWr = 1;
    while (!hostReady) @(negedge clk);
    @(negedge clk);
    hostWr = 0;
  endtask

  task automatic hostRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostRd = 1;
    while (!hostReady) @(negedge clk);
    #1 d = hostRdata;
    @(negedge clk);
    hostRd = 0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!hostReady) @(negedge clk);
  endtask

  function automatic logic [31:0] cmdWord(input logic [7:0] op, input logic [7:0] port,
                                          input logic [7:0] alo, input logic [3:0] be);
    return {op, port, alo, be, 4'h0};
  endfunction

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] rd;
    logic [39:0] k;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    cmp("R1 ready after reset", {31'd0, hostReady}, 32'd1);
    cmp("R1 req after reset", {31'd0, msgReq}, 32'd0);
    hostRead(CO, rd); cmp("R1 command word", rd, 0);
    hostRead(EO, rd); cmp("R1 upper word", rd, 0);
    hostRead(DO, rd); cmp("R1 payload word", rd, 0);

    // R2 unmapped offset
    hostWrite(8'hDC, 32'h1111_2222);
    hostRead(8'hDC, rd); cmp("R2 unmapped reads zero", rd, 0);

    // R8 normal write, BE nibble 0 in command still gives F (R5)
    ackDelay = 2;
    hostWrite(DO, 32'hCAFE_0123);
    hostWrite(EO, 32'h00AB_CD00);
    hostWrite(CO, cmdWord(8'h11, 8'h05, 8'h34, 4'h0));
    waitIdle();
    k = {8'h05, 32'h00AB_CD34};
    cmp("R8 endpoint got write", mem.exists(k) ? mem[k] : 32'hX, 32'hCAFE_0123);
    hostRead(DO, rd); cmp("R8 payload unchanged", rd, 32'hCAFE_0123);
    hostRead(EO, rd); cmp("R2 upper readback", rd, 32'h00AB_CD00);

    // R9 normal read of same location
    hostWrite(DO, 32'h0);
    hostWrite(CO, cmdWord(8'h10, 8'h05, 8'h34, 4'h0));
    waitIdle();
    hostRead(DO, rd); cmp("R9 read-back", rd, 32'hCAFE_0123);

    // R5 alternate partial write, then I/O read with immediate ack
    ackDelay = 0;
    hostWrite(DO, 32'hFFEE_DDCC);
    hostWrite(CO, cmdWord(8'h07, 8'h05, 8'h34, 4'h3));
    waitIdle();
    hostWrite(CO, cmdWord(8'h02, 8'h05, 8'h34, 4'hC));
    waitIdle();
    hostRead(DO, rd); cmp("R5 partial write merged", rd, 32'hCAFE_DDCC);

    // R3 distinct endpoint numbers keep separate data
    hostWrite(CO, cmdWord(8'h06, 8'h09, 8'h34, 4'hF));
    waitIdle();
    hostRead(DO, rd); cmp("R3 other endpoint default", rd, dflt({8'h09, 32'h00AB_CD34}));

    // R10 bad opcodes
    hostWrite(DO, 32'h5555_AAAA);
    hostWrite(CO, cmdWord(8'h21, 8'h01, 8'h00, 4'hF));
    cmp("R10 ready kept", {31'd0, hostReady}, 32'd1);
    hostRead(DO, rd); cmp("R10 bad write keeps payload", rd, 32'h5555_AAAA);
    hostWrite(CO, cmdWord(8'h20, 8'h01, 8'h00, 4'hF));
    hostRead(DO, rd); cmp("R10 bad read fills ones", rd, 32'hFFFF_FFFF);

    // R7 write offered while busy is ignored
    ackDelay = 5;
    hostWrite(CO, cmdWord(8'h10, 8'h05, 8'h34, 4'hF));
    @(negedge clk);
    hostAddr = DO; hostWdata = 32'hDEAD_BEEF; hostWr = 1;
    @(negedge clk);
    @(negedge clk);
    hostWr = 0;
    waitIdle();
    hostRead(DO, rd); cmp("R7 busy write ignored", rd, 32'hCAFE_DDCC);

    // R6 one request per launch
    repeat (3) @(negedge clk);
    cmp("R6 request count", reqRises, expLaunch);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule